// File: doc/BRIEF.md
# Asynchronous Static RAM Pin Emulator

This block stands in for an 8K x 8 asynchronous static RAM seen from its pins. A memory controller drives two chip enables (one active low, one active high), an active-low write strobe, an active-low output enable, a 13-bit address and write data. The block answers with read data and a drive-enable that tells the surrounding logic when the bidirectional bus would be driven by the memory. Everything runs on a fast internal sampling clock, so the model stays synchronous and can be built into hardware as well as used in simulation.

All control, address and data pins pass through two-flop synchronizers. A write state machine (WR_IDLE, WR_CAPTURE, WR_COMMIT) captures address and data on every sample in which a write is active. It commits the last captured pair when the write ends, whether the write strobe rises, the low enable rises or the high enable falls. A read state machine (ACC_SETTLE, ACC_READY) follows the synchronized address and holds the output at zero for a set number of sample cycles after each address change. A sticky flag reports an address that moved during an active write.

State transitions: WR_IDLE goes to WR_CAPTURE when a write becomes active. WR_CAPTURE stays while the write is active and goes to WR_COMMIT when it ends. WR_COMMIT goes to WR_CAPTURE if a new write is already active, otherwise to WR_IDLE. ACC_SETTLE goes to ACC_READY when its countdown reaches zero with no address change. Either read state goes to, or stays in, ACC_SETTLE with a reloaded count on any address change.

Top module: `sram_pin_model`

## Requirements
- R1: After reset `rdata_drive` is 0, `rdata` is 0 and `addr_viol` is 0.
- R2: The chip counts as selected only when `chip_en_n` is 0 and `chip_en` is 1. A low `wr_n` while deselected leaves the memory unchanged.
- R3: With the chip selected, holding `wr_n` low and then raising it stores the data at the address last present while it was low.
- R4: A write also commits when `chip_en_n` rises while `wr_n` is still low.
- R5: A write also commits when `chip_en` falls while `wr_n` is still low.
- R6: A few sample cycles after the pins settle, `rdata_drive` is 1 exactly when the chip is selected, `out_en_n` is 0 and `wr_n` is 1, and 0 for every other combination of the four control pins.
- R7: While reading, `rdata` follows the address. Successive addresses can be read without deselecting the chip.
- R8: After an address change, `rdata` reads 0 (the don't-care fill value) for at least ACCESS_CYC sample cycles before it shows the stored word.
- R9: If the address changes while a write is active, `addr_viol` goes to 1 and stays there until the next write begins. The word is stored at the final address.
- R10: If the write data changes while `wr_n` is low, the value present when the write ends is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en_n | input | 1 | Active-low chip enable |
| chip_en | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address (13 bits by default) |
| wdata | input | DATA_W | Data the controller drives onto the bus |
| rdata | output | DATA_W | Data the memory would drive onto the bus |
| rdata_drive | output | 1 | 1 when the memory would drive the bus, 0 for high impedance |
| addr_viol | output | 1 | Sticky flag: address moved during an active write |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=8 and ACCESS_CYC=4. The reduced address width makes a 64-word array, so every location can be written with an arithmetic pattern and read back, with each of the three write-ending edges used in rotation. The four control pins span only 16 combinations, so the bus drive rule is swept in full. The short access delay puts the fill window and the settled read within a few cycles of each address change, where both can be sampled.

// File: rtl/sram_pkg.sv
package sram_pkg;
    typedef enum logic [1:0] {
        WR_IDLE    = 2'd0,
        WR_CAPTURE = 2'd1,
        WR_COMMIT  = 2'd2
    } wr_state_t;

    typedef enum logic {
        ACC_SETTLE = 1'b0,
        ACC_READY  = 1'b1
    } acc_state_t;
endpackage

// File: rtl/sram_sync.sv
module sram_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sram_wr_ctl.sv
module sram_wr_ctl
    import sram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] wdata_s,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              viol
);
    wr_state_t         state, nxt;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE:    nxt = wr_act ? WR_CAPTURE : WR_IDLE;
            WR_CAPTURE: nxt = wr_act ? WR_CAPTURE : WR_COMMIT;
            WR_COMMIT:  nxt = wr_act ? WR_CAPTURE : WR_IDLE;
            default:    nxt = WR_IDLE;
        endcase
    end

    // capture path and violation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            viol     <= 1'b0;
        end else begin
            if (wr_act) begin
                cap_addr <= addr_s;
                cap_data <= wdata_s;
            end
            if (wr_act && state != WR_CAPTURE)
                viol <= 1'b0;
            else if (wr_act && state == WR_CAPTURE && addr_s != cap_addr)
                viol <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mem_we   = (state == WR_COMMIT);
        mem_addr = cap_addr;
        mem_data = cap_data;
    end

    // R3
    commit_follows_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_COMMIT) |-> ($past(state) == WR_CAPTURE));

    // R3
    commit_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(wr_act));

    // R9
    viol_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> ($past(wr_act) && $past(state) == WR_CAPTURE));
endmodule

// File: rtl/sram_rd_ctl.sv
module sram_rd_ctl
    import sram_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int ACCESS_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(ACCESS_CYC + 1);

    acc_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_prev;
    logic              chg;

    assign chg = (addr_s != addr_prev);

    // state register with access countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ACC_SETTLE;
            cnt       <= CNT_W'(ACCESS_CYC - 1);
            addr_prev <= '0;
        end else begin
            addr_prev <= addr_s;
            unique case (state)
                ACC_SETTLE: begin
                    if (chg)              cnt <= CNT_W'(ACCESS_CYC - 1);
                    else if (cnt == '0)   state <= ACC_READY;
                    else                  cnt <= cnt - 1'b1;
                end
                ACC_READY: begin
                    if (chg) begin
                        state <= ACC_SETTLE;
                        cnt   <= CNT_W'(ACCESS_CYC - 1);
                    end
                end
                default: state <= ACC_SETTLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_data = (state == ACC_READY) ? mem_q : '0;
    end

    // R8
    settle_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (state == ACC_SETTLE));

    // R8
    ready_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ACC_READY) |-> ($past(cnt) == '0));
endmodule

// File: rtl/sram_pin_model.sv
module sram_pin_model #(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int ACCESS_CYC = 3,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              chip_en,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive,
    output logic              addr_viol
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [3:0]        ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    logic              sel, wr_act, rd_act;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] mem [DEPTH];

    // control bundle order: {chip_en_n, chip_en, wr_n, out_en_n}
    sram_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b1011)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({chip_en_n, chip_en, wr_n, out_en_n}), .q(ctl_s));

    sram_sync #(.W(ADDR_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));

    sram_sync #(.W(DATA_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d(wdata), .q(wdata_s));

    assign sel    = !ctl_s[3] && ctl_s[2];
    assign wr_act = sel && !ctl_s[1];
    assign rd_act = sel && ctl_s[1] && !ctl_s[0];

    sram_wr_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act),
        .addr_s(addr_s), .wdata_s(wdata_s),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .viol(addr_viol));

    sram_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACCESS_CYC(ACCESS_CYC)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr_s(addr_s), .mem_q(mem_q),
        .rd_data(rdata));

    // storage array: commit port and address-following read
    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_data;
        mem_q <= mem[addr_s];
    end

    assign rdata_drive = rd_act;

    // R6
    no_drive_while_writing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_drive |-> !u_wr.viol || !wr_act);

    // R2
    commit_needs_prior_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_we) || $past(sel, 2));
endmodule

// File: tb/tb_sram_pin_model.sv
`timescale 1ns/1ps
module tb_sram_pin_model;
    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int ACC = 4;
    localparam int N   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_en_n, chip_en, wr_n, out_en_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_drive, addr_viol;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [DW-1:0] exp_mem [N];

    always #2.5 clk = ~clk;

    sram_pin_model #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC)) dut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .chip_en(chip_en),
        .wr_n(wr_n), .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive), .addr_viol(addr_viol));

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 37 + 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        chip_en_n = 1'b1; chip_en = 1'b1; wr_n = 1'b1; out_en_n = 1'b1;
    endtask

    // mode 0: wr_n rises, 1: chip_en_n rises, 2: chip_en falls
    task automatic do_write(input int a, input logic [DW-1:0] d, input int mode);
        @(negedge clk);
        addr = AW'(a); wdata = d;
        chip_en_n = 1'b0; chip_en = 1'b1; wr_n = 1'b0; out_en_n = 1'b1;
        wait_n(3);
        case (mode)
            0: wr_n = 1'b1;
            1: chip_en_n = 1'b1;
            default: chip_en = 1'b0;
        endcase
        wait_n(3);
        idle();
        wait_n(3);
        exp_mem[a] = d;
    endtask

    task automatic do_read(input int a, output logic [DW-1:0] d, output logic drv);
        @(negedge clk);
        addr = AW'(a);
        chip_en_n = 1'b0; chip_en = 1'b1; wr_n = 1'b1; out_en_n = 1'b0;
        wait_n(10);
        d = rdata; drv = rdata_drive;
    endtask

    initial begin
        logic [DW-1:0] d;
        logic drv;
        rst_n = 1'b0; idle(); addr = '0; wdata = '0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 drive", 32'(rdata_drive), 0);
        chk("R1 rdata", 32'(rdata), 0);
        chk("R1 viol", 32'(addr_viol), 0);

        // exhaustive write with rotating end edge, then read back
        for (int a = 0; a < N; a++) do_write(a, pat(a), a % 3);
        for (int a = 0; a < N; a++) begin
            do_read(a, d, drv);
            chk($sformatf("R3/R7 read addr %0d", a), 32'(d), 32'(pat(a)));
        end
        chk("R7 drive during read", 32'(drv), 1);
        idle(); wait_n(3);

        // R4, R5 dedicated
        do_write(7, 8'hC3, 1);
        do_read(7, d, drv);
        chk("R4 commit on chip_en_n rise", 32'(d), 32'hC3);
        do_write(8, 8'h3C, 2);
        do_read(8, d, drv);
        chk("R5 commit on chip_en fall", 32'(d), 32'h3C);

        // R2 deselected writes ignored
        @(negedge clk);
        addr = AW'(5); wdata = 8'hEE;
        chip_en_n = 1'b1; chip_en = 1'b1; wr_n = 1'b0; wait_n(4);
        wr_n = 1'b1; wait_n(2);
        chip_en_n = 1'b0; chip_en = 1'b0; wr_n = 1'b0; wait_n(4);
        wr_n = 1'b1; wait_n(2);
        idle(); wait_n(3);
        do_read(5, d, drv);
        chk("R2 deselected write ignored", 32'(d), 32'(exp_mem[5]));

        // R6 full sweep of control pins, bits {chip_en_n, chip_en, wr_n, out_en_n}
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            addr = AW'(N - 1); wdata = exp_mem[N - 1];
            {chip_en_n, chip_en, wr_n, out_en_n} = 4'(v);
            wait_n(4);
            chk($sformatf("R6 drive ctl=%0h", v), 32'(rdata_drive),
                32'((v[3] == 1'b0 && v[2] && v[1] && v[0] == 1'b0) ? 1 : 0));
        end
        idle(); wait_n(3);

        // R8 access window then settled data
        do_read(2, d, drv);
        @(negedge clk);
        addr = AW'(3);
        wait_n(4);
        chk("R8 fill during access", 32'(rdata), 0);
        wait_n(6);
        chk("R8 data after access", 32'(rdata), 32'(exp_mem[3]));
        idle(); wait_n(3);

        // R9 address moves during write
        @(negedge clk);
        addr = AW'(10); wdata = 8'h5A;
        chip_en_n = 1'b0; chip_en = 1'b1; wr_n = 1'b0; out_en_n = 1'b1;
        wait_n(3);
        addr = AW'(11);
        wait_n(3);
        wr_n = 1'b1;
        wait_n(3);
        idle(); wait_n(3);
        chk("R9 flag set", 32'(addr_viol), 1);
        exp_mem[11] = 8'h5A;
        do_read(11, d, drv);
        chk("R9 stored at final addr", 32'(d), 32'h5A);
        do_read(10, d, drv);
        chk("R9 first addr untouched", 32'(d), 32'(exp_mem[10]));
        chk("R9 flag sticky", 32'(addr_viol), 1);
        idle(); wait_n(3);
        do_write(12, 8'h21, 0);
        chk("R9 flag cleared by next write", 32'(addr_viol), 0);

        // R10 data changes while strobe low
        @(negedge clk);
        addr = AW'(20); wdata = 8'h11;
        chip_en_n = 1'b0; chip_en = 1'b1; wr_n = 1'b0; out_en_n = 1'b1;
        wait_n(3);
        wdata = 8'h77;
        wait_n(3);
        wr_n = 1'b1;
        wait_n(3);
        idle(); wait_n(3);
        do_read(20, d, drv);
        chk("R10 last data stored", 32'(d), 32'h77);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule